// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. Software starts a conversion by writing a start request. The block stops sampling at once and then works through the result one bit per conversion-clock period, most significant bit first. At each step it presents a trial code to an external DAC and comparator and reads back one decision bit. When every bit is settled it copies the code into the result register, clears the busy/start bit and raises a sticky interrupt flag.

The conversion clock comes from one of two sources. The first is a divided copy of the system clock, with the ratio set by a select field. The second is a free-running RC clock input, which the block synchronises into the system domain. When the RC source is chosen, the block waits one system-clock cycle before any conversion-clock edge can count. The result register keeps its previous value for the whole conversion. Software may cancel a running conversion, and the result register is then left as it was.

Top module: `sar_seq_ctrl`

## Requirements
- R1: `clk_sel` values 0 to 5 select a system-clock divider of 2, 4, 8, 16, 32 or 64 (ratio = 2 << clk_sel). Values 6 and 7 select the RC clock input.
- R2: In divider mode, `go` stays high for exactly 11 × ratio system-clock cycles after the edge that accepts the start. That is 11 conversion-clock periods: 10 bit trials plus one completion period.
- R3: Bits are resolved from bit 9 down to bit 0. Each trial sets the bit under test to 1 in `trial_code`. The bit stays 1 if `cmp_ge` is 1 (input at or above the DAC level) and is cleared otherwise. With an ideal comparator the final result is the input code.
- R4: `sampling` goes low on the same edge that raises `go`. It stays low for the whole conversion and returns high on the edge where `go` clears.
- R5: `result` keeps its previous value for the whole conversion. It changes only on the completion edge.
- R6: On completion, `go` clears and `irq_flag` sets on the same edge. The new result can be read in the following cycle.
- R7: When the RC source is selected, an RC rising edge that reaches the synchronised domain in the cycle directly after the start edge is not counted as a conversion-clock edge.
- R8: A `go_set` pulse while `go` is high has no effect. The conversion keeps its timing and its result.
- R9: A `go_clr` pulse while `go` is high aborts the conversion. `go` clears on the next edge, `result` is unchanged and `irq_flag` is not set.
- R10: `irq_flag` stays set until a `flag_clr` pulse. If a completion and `flag_clr` arrive on the same edge, the set wins.
- R11: A synchronous `rst` clears `go`, `irq_flag`, `result` and `trial_code`, and sets `sampling` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| go_set | input | 1 | Software write of 1 to the start bit (one-cycle pulse) |
| go_clr | input | 1 | Software write of 0 to the start bit (one-cycle pulse) |
| clk_sel | input | 3 | Conversion clock source and divider select |
| rc_clk | input | 1 | Free-running RC clock, asynchronous to `clk` |
| cmp_ge | input | 1 | Comparator decision: input at or above DAC output |
| flag_clr | input | 1 | Clear pulse for the interrupt flag |
| go | output | 1 | Start/busy bit; reads 0 when done |
| sampling | output | 1 | Hold path connected to the input |
| trial_code | output | 10 | Code presented to the DAC |
| result | output | 10 | Result register |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The hardest case to reach from the ports is an RC edge that arrives in the single system cycle right after the start edge, where the inserted delay must swallow it. The bench stops the free-running RC clock and drives it by hand. It raises the RC line exactly one cycle before the start request, so that the synchronised edge lands in that cycle. It then checks that the trial code has not advanced. Start requests during a conversion and cancels part way through are placed at chosen cycle offsets. The duration and the held old result show whether the start request was ignored and whether the cancel took effect.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W       = 10;  // result width
  localparam int SEL_W       = 3;   // clock select width
  localparam int DIV_SEL_MAX = 5;   // highest divider select, larger = RC
  localparam int CNT_W       = DIV_SEL_MAX + 1;  // counter for the largest ratio
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen #(
  parameter int SEL_W       = sar_seq_pkg::SEL_W,
  parameter int DIV_SEL_MAX = sar_seq_pkg::DIV_SEL_MAX,
  parameter int CNT_W       = DIV_SEL_MAX + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             start,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             rc_clk,
  output logic             tick
);
  // last count value of the divider for a select code (ratio = 2 << sel)
  function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    return CNT_W'((32'd2 << sel) - 32'd1);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [2:0]       rc_sync;
  logic             rc_hold;
  logic             rc_mode;
  logic             div_tick;
  logic             rc_edge;
  logic             rc_tick;

  assign rc_mode  = (int'(clk_sel) > DIV_SEL_MAX);
  assign div_tick = active && !rc_mode && (cnt == div_last(clk_sel));
  assign rc_edge  = rc_sync[1] && !rc_sync[2];
  assign rc_tick  = active && rc_mode && !rc_hold && rc_edge;
  assign tick     = div_tick || rc_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rc_sync <= '0;
      rc_hold <= 1'b0;
    end else begin
      rc_sync <= {rc_sync[1:0], rc_clk};
      rc_hold <= start && rc_mode;
      if (start || !active || div_tick) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  // R7: the cycle after a start in RC mode yields no conversion-clock edge
  assert_rc_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (start && rc_mode) |=> !tick);
  // R2: conversion-clock edges are single-cycle events
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && $stable(clk_sel)) |=> !tick);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W  = sar_seq_pkg::RES_W,
  parameter int STEP_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] code,
  output logic             finish
);
  // one trial step: decide bit idx, then place a 1 in the next lower bit
  function automatic logic [RES_W-1:0] trial_next(input logic [RES_W-1:0] cur,
                                                   input int idx, input logic keep);
    logic [RES_W-1:0] nxt;
    nxt = cur;
    if (!keep) nxt[idx] = 1'b0;
    if (idx > 0) nxt[idx-1] = 1'b1;
    return nxt;
  endfunction

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_W);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic              trial_evt;
  int                bit_idx;

  assign bit_idx   = RES_W - 1 - int'(step);
  assign trial_evt = busy && tick && (step != LAST_STEP);
  assign finish    = busy && tick && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      code <= '0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      code <= RES_W'(1) << (RES_W - 1);
      step <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      code <= '0;
      step <= '0;
    end else if (trial_evt) begin
      code <= trial_next(code, bit_idx, cmp_ge);
      step <= step + 1'b1;
    end
  end

  // R3: every conversion begins with only the MSB under trial
  assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !abort) |=> (code == (RES_W'(1) << (RES_W - 1))));
  // R3: the decided bit equals the comparator decision of its trial
  assert_bit_decision_R3: assert property (@(posedge clk) disable iff (rst)
    (trial_evt && !abort && !start) |=> (code[RES_W - 1 - int'($past(step))] == $past(cmp_ge)));
  // R2: the step counter never passes the completion step
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step <= LAST_STEP));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES_W       = sar_seq_pkg::RES_W,
  parameter int SEL_W       = sar_seq_pkg::SEL_W,
  parameter int DIV_SEL_MAX = sar_seq_pkg::DIV_SEL_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             rc_clk,
  input  logic             cmp_ge,
  input  logic             flag_clr,
  output logic             go,
  output logic             sampling,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result,
  output logic             irq_flag
);
  logic             conv_start;
  logic             conv_abort;
  logic             tad_tick;
  logic             eng_finish;
  logic             done_evt;
  logic [RES_W-1:0] eng_code;

  assign conv_start = go_set && !go;
  assign conv_abort = go_clr && go;
  assign done_evt   = eng_finish && !conv_abort;

  sar_tad_gen #(.SEL_W(SEL_W), .DIV_SEL_MAX(DIV_SEL_MAX)) tad_i (
    .clk(clk), .rst(rst), .active(go), .start(conv_start),
    .clk_sel(clk_sel), .rc_clk(rc_clk), .tick(tad_tick)
  );

  sar_bit_engine #(.RES_W(RES_W)) eng_i (
    .clk(clk), .rst(rst), .start(conv_start), .abort(conv_abort),
    .tick(tad_tick), .cmp_ge(cmp_ge), .code(eng_code), .finish(eng_finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      go       <= 1'b0;
      result   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (conv_start)                   go <= 1'b1;
      else if (conv_abort || done_evt)  go <= 1'b0;
      if (done_evt) result <= eng_code;
      if (done_evt)      irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  assign sampling   = !go;
  assign trial_code = eng_code;

  // R5: result only moves on a completion
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !done_evt |=> $stable(result));
  // R6: completion drops go and raises the flag together
  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (!go && irq_flag && sampling));
  // R8: a busy conversion keeps running unless cleared or finished
  assert_busy_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (go && !go_clr && !eng_finish) |=> go);
  // R9: an abort leaves no flag set by this conversion
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (go && go_clr && !irq_flag) |=> (!go && !irq_flag));
  // R10: the flag is sticky until cleared
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);
endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go_set = 1'b0, go_clr = 1'b0, flag_clr = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       rc_clk = 1'b0;
  logic       rc_run = 1'b0;
  logic [9:0] vin = 10'd0;
  logic       cmp_ge;
  logic       go, sampling, irq_flag;
  logic [9:0] trial_code, result;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  initial forever #37 if (rc_run) rc_clk = ~rc_clk;

  // ideal DAC plus comparator
  assign cmp_ge = (vin >= trial_code);

  sar_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .go_set(go_set), .go_clr(go_clr), .clk_sel(clk_sel),
    .rc_clk(rc_clk), .cmp_ge(cmp_ge), .flag_clr(flag_clr), .go(go),
    .sampling(sampling), .trial_code(trial_code), .result(result), .irq_flag(irq_flag)
  );

  // bench model of a binary search against an ideal comparator
  function automatic logic [9:0] sar_model(input logic [9:0] v);
    logic [9:0] acc = '0;
    for (int b = 9; b >= 0; b--) begin
      acc[b] = 1'b1;
      if (v < acc) acc[b] = 1'b0;
    end
    return acc;
  endfunction

  function automatic int ratio_of(input logic [2:0] s);
    int r = 1;
    for (int i = 0; i <= int'(s); i++) r = r * 2;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one conversion; midgo>0 issues an extra go_set at that cycle
  task automatic run_conv(input logic [2:0] s, input logic [9:0] v, input int midgo,
                          output int cyc, output int held_bad);
    logic [9:0] old;
    vin = v; clk_sel = s; old = result;
    cyc = 0; held_bad = 0;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    while (go && cyc < 5000) begin
      if (result !== old || sampling !== 1'b0) held_bad++;
      go_set = (cyc == midgo) ? 1'b1 : 1'b0;
      @(negedge clk);
      cyc++;
    end
    go_set = 1'b0;
  endtask

  initial begin
    int cyc, bad;
    logic [9:0] v, keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(go == 0 && irq_flag == 0 && result == 0 && trial_code == 0 && sampling == 1,
          "R11 reset state", {go, irq_flag, sampling}, 1);

    // every divider ratio with a corner or random input
    for (int s = 0; s <= 5; s++) begin
      v = (s == 0) ? 10'd0 : (s == 1) ? 10'd1023 : (s == 2) ? 10'd512 :
          (s == 3) ? 10'd511 : 10'($urandom(32'd7 + s));
      run_conv(3'(s), v, -1, cyc, bad);
      check(cyc == 11 * ratio_of(3'(s)), "R1 R2 conversion length", cyc, 11 * ratio_of(3'(s)));
      check(result == sar_model(v), "R3 result value", result, sar_model(v));
      check(bad == 0, "R4 R5 sampling low and old result held", bad, 0);
      check(irq_flag == 1 && sampling == 1, "R6 done flag and sample return", irq_flag, 1);
    end

    // sticky flag, then clear
    repeat (20) @(negedge clk);
    check(irq_flag == 1, "R10 flag stays set", irq_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(irq_flag == 0, "R10 flag clear", irq_flag, 1'b0);

    // start request while busy is ignored
    run_conv(3'd1, 10'd300, 5, cyc, bad);
    check(cyc == 44, "R8 busy start ignored (length)", cyc, 44);
    check(result == 10'd300, "R8 busy start ignored (result)", result, 300);

    // abort mid conversion
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    keep = result; vin = 10'd77; clk_sel = 3'd3;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    repeat (30) @(negedge clk);
    go_clr = 1'b1; @(negedge clk); go_clr = 1'b0;
    check(go == 0, "R9 abort clears go", go, 0);
    repeat (200) @(negedge clk);
    check(result == keep && irq_flag == 0, "R9 abort keeps result, no flag", result, keep);

    // RC edge landing in the inserted delay cycle is not counted
    clk_sel = 3'd6; vin = 10'd5; rc_clk = 1'b0;
    repeat (5) @(negedge clk);
    rc_clk = 1'b1;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    repeat (6) @(negedge clk);
    check(trial_code == 10'h200, "R7 RC edge in delay cycle ignored", trial_code, 10'h200);
    go_clr = 1'b1; @(negedge clk); go_clr = 1'b0;
    rc_clk = 1'b0;
    repeat (4) @(negedge clk);

    // free-running RC clock
    rc_run = 1'b1;
    run_conv(3'd7, 10'd689, -1, cyc, bad);
    check(result == sar_model(10'd689) && cyc < 300, "R1 R3 RC conversion", result, 689);
    rc_run = 1'b0;

    // completion and flag clear on the same edge: set wins
    flag_clr = 1'b0;
    vin = 10'd42; clk_sel = 3'd0;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    repeat (21) @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(go == 0 && irq_flag == 1, "R10 set beats clear", irq_flag, 1);

    // random conversions
    for (int i = 0; i < 40; i++) begin
      logic [2:0] s;
      s = 3'($urandom % 5);
      v = 10'($urandom);
      run_conv(s, v, -1, cyc, bad);
      check(result == sar_model(v) && cyc == 11 * ratio_of(s) && bad == 0,
            "R2 R3 R5 random conversion", result, sar_model(v));
    end

    // reset mid conversion
    vin = 10'd900; clk_sel = 3'd2;
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(go == 0 && irq_flag == 0 && result == 0 && trial_code == 0, "R11 reset mid conversion",
          result, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule